// File: doc/BRIEF.md
# Parallel Port Interrupt Flag Controller

This block is the interrupt-flag part of a two-port parallel interface adapter. Four external handshake lines (two per port) are watched for edges. Each line's active edge is picked by a per-line polarity setting in the peripheral control register. Matching edges latch a flag bit. A shift-complete request and two timer expiry requests also set flags, but they set on every asserted cycle rather than on an edge. The interrupt output is asserted while any flag is set whose enable bit is also set.

Software reaches the block through a 4-bit register-select bus with read and write strobes. Reads return data combinationally in the same cycle. Read side effects and writes take effect at the clock edge. The bus holds the two port output registers, their direction registers, the control register, the flag register and the enable register.

Accessing a port output register acknowledges that port's handshake flags. The second handshake line of each port can be placed in an independent mode. In that mode its flag survives port accesses and must be cleared by a write to the flag register.

Top module: `via_irq_ctl`

## Requirements
- R1: After reset, all port, direction and control registers read 0x00. The flag register reads 0x00, the enable register reads 0x80 and `irq` is low. The remembered level of every handshake line is 0. Select codes are: 0 port B, 1 port A, 2 port B direction, 3 port A direction, 10 shift register, 12 control, 13 flags, 14 enables, 15 port A without handshake. The other codes read 0x00.
- R2: Flag bit 1 (line `ca1`) and flag bit 4 (line `cb1`) are set by a rising edge when control bit 0 (for `ca1`) or control bit 4 (for `cb1`) is 1. They are set by a falling edge when that bit is 0.
- R3: Flag bit 0 (line `ca2`) and flag bit 3 (line `cb2`) are set by a rising edge when control bit 2 (for `ca2`) or control bit 6 (for `cb2`) is 1. They are set by a falling edge when that bit is 0.
- R4: A handshake line whose sampled level equals its remembered level sets nothing. A line held at its active level does not set its flag again after the flag is cleared.
- R5: `sr_req` sets flag bit 2 on every cycle it is high, not only on an edge. A read of select code 10 clears flag bit 2.
- R6: `t1_expire` sets flag bit 6 and `t2_expire` sets flag bit 5 on every cycle they are high.
- R7: A read or write of port B (code 0) clears flag bit 4. It also clears flag bit 3 unless control bit 5 (independent mode for `cb2`) is 1.
- R8: A read or write of port A (code 1 or 15) clears flag bit 1. It also clears flag bit 0 unless control bit 1 (independent mode for `ca2`) is 1.
- R9: A write to a port output register changes only the bits whose direction bit is 1. The other bits keep their value.
- R10: Writing the flag register (code 13) clears each flag in bits 6:0 written as 1. Flag register bit 7 reads 1 when any enabled flag is set.
- R11: Writing the enable register (code 14) with bit 7 = 1 sets the enable bits written as 1 in bits 6:0. With bit 7 = 0 it clears them. Bit 7 always reads 1.
- R12: `irq` is high exactly when some flag bit in 6:0 is set together with its enable bit.
- R13: When a flag's set condition and a clear from a bus access occur in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 4 | Register select |
| rd_en | input | 1 | Read strobe (side effects at clock edge) |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| ca1 | input | 1 | Port A handshake line 1 |
| ca2 | input | 1 | Port A handshake line 2 |
| cb1 | input | 1 | Port B handshake line 1 |
| cb2 | input | 1 | Port B handshake line 2 |
| sr_req | input | 1 | Shift-complete request |
| t1_expire | input | 1 | Timer 1 expiry request |
| t2_expire | input | 1 | Timer 2 expiry request |
| pa_out | output | 8 | Port A output register |
| pb_out | output | 8 | Port B output register |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a flag's set condition and its clear condition arriving at the same clock edge. This happens when a handshake edge coincides with the port access that acknowledges it, or when a held shift request coincides with a shift-register read. The stimulus reaches it by changing the line level and raising the read strobe at the same falling clock edge. The flag register is then read back with no side effect. A second hard case is the independent mode, where a port access must leave the second line's flag alone. The bench sets both flags of a port and then accesses the port, once with the mode off and once with it on.

// File: rtl/via_pkg.sv
package via_pkg;
  localparam int DW     = 8;
  localparam int SELW   = 4;
  localparam int NFLAG  = 7;
  localparam int NLINE  = 4;

  typedef enum logic [SELW-1:0] {
    SEL_PB     = 4'd0,
    SEL_PA     = 4'd1,
    SEL_DIRB   = 4'd2,
    SEL_DIRA   = 4'd3,
    SEL_T1LO   = 4'd4,
    SEL_T1HI   = 4'd5,
    SEL_T1LLO  = 4'd6,
    SEL_T1LHI  = 4'd7,
    SEL_T2LO   = 4'd8,
    SEL_T2HI   = 4'd9,
    SEL_SHIFT  = 4'd10,
    SEL_AUX    = 4'd11,
    SEL_PCTL   = 4'd12,
    SEL_FLAGS  = 4'd13,
    SEL_ENABLE = 4'd14,
    SEL_PA_NH  = 4'd15
  } via_sel_e;

  // flag bit positions (decoded by software)
  localparam int FB_CA2 = 0;
  localparam int FB_CA1 = 1;
  localparam int FB_SR  = 2;
  localparam int FB_CB2 = 3;
  localparam int FB_CB1 = 4;
  localparam int FB_T2  = 5;
  localparam int FB_T1  = 6;

  // line vector order
  localparam int LN_CA1 = 0;
  localparam int LN_CA2 = 1;
  localparam int LN_CB1 = 2;
  localparam int LN_CB2 = 3;

  function automatic logic [DW-1:0] merge_port(input logic [DW-1:0] old_v,
                                               input logic [DW-1:0] new_v,
                                               input logic [DW-1:0] dir);
    return (old_v & ~dir) | (new_v & dir);
  endfunction

  function automatic logic edge_hit(input logic prev, input logic now, input logic pos);
    return (prev != now) && (now == pos);
  endfunction

  function automatic logic [NFLAG-1:0] flag_next(input logic [NFLAG-1:0] cur,
                                                 input logic [NFLAG-1:0] set,
                                                 input logic [NFLAG-1:0] clr);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/via_line_edge.sv
module via_line_edge
  import via_pkg::*;
#(
  parameter int LINES = NLINE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] line,
  input  logic [LINES-1:0] pos_sel,
  output logic [LINES-1:0] hit,
  output logic [LINES-1:0] prev_q
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[g] <= 1'b0;
      else        prev_q[g] <= line[g];
    end
    assign hit[g] = edge_hit(prev_q[g], line[g], pos_sel[g]);
  end
endmodule

// File: rtl/via_flag_bank.sv
module via_flag_bank
  import via_pkg::*;
#(
  parameter int NF = NFLAG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set,
  input  logic [NF-1:0] clr,
  input  logic          en_wr,
  input  logic [NF:0]   en_wdata,
  output logic [NF-1:0] flags,
  output logic [NF-1:0] enables,
  output logic          irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags   <= '0;
      enables <= '0;
    end else begin
      flags <= flag_next(flags, set, clr);
      if (en_wr) begin
        if (en_wdata[NF]) enables <= enables | en_wdata[NF-1:0];
        else              enables <= enables & ~en_wdata[NF-1:0];
      end
    end
  end

  assign irq = |(flags & enables);

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set != '0) |=> ((flags & $past(set)) == $past(set))); // R13
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr & ~set) != '0) |=> ((flags & $past(clr & ~set)) == '0)); // R10
endmodule

// File: rtl/via_irq_ctl.sv
module via_irq_ctl
  import via_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] sel,
  input  logic       rd_en,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       ca1,
  input  logic       ca2,
  input  logic       cb1,
  input  logic       cb2,
  input  logic       sr_req,
  input  logic       t1_expire,
  input  logic       t2_expire,
  output logic [7:0] pa_out,
  output logic [7:0] pb_out,
  output logic       irq
);
  via_sel_e          rsel;
  logic [DW-1:0]     orb_q, ora_q, ddrb_q, ddra_q, pcr_q;
  logic [NLINE-1:0]  lines, pos_sel, hit, prev_q;
  logic [NFLAG-1:0]  set_v, clr_v, flags, enables;
  logic              acc, acc_a, acc_b, wr_a, wr_b;

  assign rsel  = via_sel_e'(sel);
  assign acc   = rd_en | wr_en;
  assign acc_b = acc && (rsel == SEL_PB);
  assign acc_a = acc && ((rsel == SEL_PA) || (rsel == SEL_PA_NH));
  assign wr_b  = wr_en && (rsel == SEL_PB);
  assign wr_a  = wr_en && ((rsel == SEL_PA) || (rsel == SEL_PA_NH));

  // line vector and per-line active polarity from the control register
  assign lines   = {cb2, cb1, ca2, ca1};
  assign pos_sel = {pcr_q[6], pcr_q[4], pcr_q[2], pcr_q[0]};

  via_line_edge #(.LINES(NLINE)) u_edge (
    .clk(clk), .rst_n(rst_n), .line(lines), .pos_sel(pos_sel),
    .hit(hit), .prev_q(prev_q)
  );

  always_comb begin
    set_v         = '0;
    set_v[FB_CA2] = hit[LN_CA2];
    set_v[FB_CA1] = hit[LN_CA1];
    set_v[FB_SR]  = sr_req;
    set_v[FB_CB2] = hit[LN_CB2];
    set_v[FB_CB1] = hit[LN_CB1];
    set_v[FB_T2]  = t2_expire;
    set_v[FB_T1]  = t1_expire;

    clr_v         = '0;
    if (wr_en && (rsel == SEL_FLAGS)) clr_v = wdata[NFLAG-1:0];
    clr_v[FB_CA1] = clr_v[FB_CA1] | acc_a;
    clr_v[FB_CA2] = clr_v[FB_CA2] | (acc_a & ~pcr_q[1]);
    clr_v[FB_CB1] = clr_v[FB_CB1] | acc_b;
    clr_v[FB_CB2] = clr_v[FB_CB2] | (acc_b & ~pcr_q[5]);
    clr_v[FB_SR]  = clr_v[FB_SR]  | (rd_en && (rsel == SEL_SHIFT));
  end

  via_flag_bank #(.NF(NFLAG)) u_flags (
    .clk(clk), .rst_n(rst_n), .set(set_v), .clr(clr_v),
    .en_wr(wr_en && (rsel == SEL_ENABLE)), .en_wdata(wdata),
    .flags(flags), .enables(enables), .irq(irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      orb_q  <= '0;
      ora_q  <= '0;
      ddrb_q <= '0;
      ddra_q <= '0;
      pcr_q  <= '0;
    end else if (wr_en) begin
      unique case (rsel)
        SEL_PB:             orb_q  <= merge_port(orb_q, wdata, ddrb_q);
        SEL_PA, SEL_PA_NH:  ora_q  <= merge_port(ora_q, wdata, ddra_q);
        SEL_DIRB:           ddrb_q <= wdata;
        SEL_DIRA:           ddra_q <= wdata;
        SEL_PCTL:           pcr_q  <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (rsel)
      SEL_PB:            rdata = orb_q;
      SEL_PA, SEL_PA_NH: rdata = ora_q;
      SEL_DIRB:          rdata = ddrb_q;
      SEL_DIRA:          rdata = ddra_q;
      SEL_PCTL:          rdata = pcr_q;
      SEL_FLAGS:         rdata = {irq, flags};
      SEL_ENABLE:        rdata = {1'b1, enables};
      default:           rdata = '0;
    endcase
  end

  assign pa_out = ora_q;
  assign pb_out = orb_q;

  AST_PB_CLEARS_CB1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_b && !hit[LN_CB1]) |=> !flags[FB_CB1]); // R7
  AST_PA_KEEPS_INDEP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_a && pcr_q[1] && flags[FB_CA2]) |=> flags[FB_CA2]); // R8
  AST_DDR_MASK_A: assert property (@(posedge clk) disable iff (!rst_n)
    wr_a |=> ((pa_out & ~ddra_q) == ($past(pa_out) & ~ddra_q))); // R9
  AST_DDR_MASK_B: assert property (@(posedge clk) disable iff (!rst_n)
    wr_b |=> ((pb_out & ~ddrb_q) == ($past(pb_out) & ~ddrb_q))); // R9
  AST_EDGE_NEEDED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[FB_CA1]) |-> $past(ca1 != prev_q[LN_CA1])); // R4
  AST_SR_EVERY: assert property (@(posedge clk) disable iff (!rst_n)
    sr_req |=> flags[FB_SR]); // R5
endmodule

// File: tb/sim_via_irq_ctl.sv
module sim_via_irq_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] sel = '0;
  logic rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, pa_out, pb_out;
  logic ca1 = 0, ca2 = 0, cb1 = 0, cb2 = 0;
  logic sr_req = 0, t1_expire = 0, t2_expire = 0;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  via_irq_ctl u0 (.*);

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] s, input logic [7:0] d);
    @(negedge clk); sel = s; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] s, output logic [7:0] d);
    @(negedge clk); sel = s; rd_en = 1; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic peek_flags(output logic [7:0] d);
    @(negedge clk); sel = 4'd13; #1 d = rdata;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(4'd0, d);  chk("R1 port B", d, 8'h00);
    rd(4'd3, d);  chk("R1 dir A", d, 8'h00);
    rd(4'd12, d); chk("R1 control", d, 8'h00);
    rd(4'd13, d); chk("R1 flags", d, 8'h00);
    rd(4'd14, d); chk("R1 enables", d, 8'h80);
    rd(4'd5, d);  chk("R1 unused code", d, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_enable;
    logic [7:0] d;
    wr(4'd14, 8'h83); rd(4'd14, d); chk("R11 set", d, 8'h83);
    wr(4'd14, 8'h01); rd(4'd14, d); chk("R11 clear", d, 8'h82);
    wr(4'd14, 8'h7F); rd(4'd14, d); chk("R11 clear all", d, 8'h80);
  endtask

  task automatic t_line1;
    logic [7:0] d;
    wr(4'd12, 8'h00);
    @(negedge clk); ca1 = 1; tick(1);
    peek_flags(d); chk("R2 ca1 rise ignored when neg", d, 8'h00);
    @(negedge clk); ca1 = 0; tick(1);
    peek_flags(d); chk("R2 ca1 fall sets", d, 8'h02);
    rd(4'd1, d);
    wr(4'd12, 8'h11);
    @(negedge clk); ca1 = 1; cb1 = 1; tick(1);
    peek_flags(d); chk("R2 ca1/cb1 rise sets", d, 8'h12);
    wr(4'd13, 8'h7F);
    tick(5);
    peek_flags(d); chk("R4 held level no reset", d, 8'h00);
    @(negedge clk); ca1 = 0; cb1 = 0; tick(1);
    peek_flags(d); chk("R2 fall ignored when pos", d, 8'h00);
  endtask

  task automatic t_line2;
    logic [7:0] d;
    wr(4'd12, 8'h04);  // ca2 rising, cb2 falling
    @(negedge clk); ca2 = 1; cb2 = 1; tick(1);
    peek_flags(d); chk("R3 ca2 rise / cb2 rise", d, 8'h01);
    @(negedge clk); ca2 = 0; cb2 = 0; tick(1);
    peek_flags(d); chk("R3 cb2 fall", d, 8'h09);
    wr(4'd13, 8'h09);
    peek_flags(d); chk("R10 write-one clear", d, 8'h00);
  endtask

  task automatic t_sr_timers;
    logic [7:0] d;
    @(negedge clk); sr_req = 1; @(negedge clk); sr_req = 0;
    peek_flags(d); chk("R5 sr sets", d, 8'h04);
    rd(4'd10, d);
    peek_flags(d); chk("R5 sr read clears", d, 8'h00);
    @(negedge clk); sr_req = 1;
    rd(4'd10, d);
    peek_flags(d); chk("R13 sr held beats read", d, 8'h04);
    @(negedge clk); sr_req = 0;
    rd(4'd10, d);
    peek_flags(d); chk("R5 sr cleared after drop", d, 8'h00);
    @(negedge clk); t1_expire = 1; @(negedge clk); t1_expire = 0; t2_expire = 1;
    @(negedge clk); t2_expire = 0;
    peek_flags(d); chk("R6 timers", d, 8'h60);
    wr(4'd13, 8'h40);
    peek_flags(d); chk("R10 partial clear", d, 8'h20);
    wr(4'd13, 8'h20);
  endtask

  task automatic t_portb;
    logic [7:0] d;
    wr(4'd12, 8'h50);  // cb1 pos, cb2 pos, not independent
    @(negedge clk); cb1 = 1; cb2 = 1; tick(1);
    rd(4'd0, d);
    peek_flags(d); chk("R7 port B clears both", d, 8'h00);
    wr(4'd12, 8'h30);  // cb1 pos, cb2 neg independent
    @(negedge clk); cb1 = 0; cb2 = 0; tick(1);
    @(negedge clk); cb1 = 1; tick(1);
    peek_flags(d); chk("R7 setup", d, 8'h18);
    wr(4'd0, 8'hAA);
    peek_flags(d); chk("R7 independent cb2 kept", d, 8'h08);
    wr(4'd13, 8'h08);
  endtask

  task automatic t_porta;
    logic [7:0] d;
    wr(4'd12, 8'h05);  // ca1 pos, ca2 pos
    @(negedge clk); ca1 = 1; ca2 = 1; tick(1);
    rd(4'd15, d);
    peek_flags(d); chk("R8 no-handshake read clears both", d, 8'h00);
    wr(4'd12, 8'h07);  // ca2 independent
    @(negedge clk); ca1 = 0; ca2 = 0; tick(1);
    wr(4'd12, 8'h06);  // ca1 neg, ca2 pos independent
    @(negedge clk); ca1 = 1; tick(1);
    @(negedge clk); ca1 = 0; ca2 = 1; tick(1);
    peek_flags(d); chk("R8 setup", d, 8'h03);
    rd(4'd1, d);
    peek_flags(d); chk("R8 independent ca2 kept", d, 8'h01);
    wr(4'd13, 8'h01);
    @(negedge clk); ca2 = 0;
    // same-cycle edge and acknowledge
    @(negedge clk); ca1 = 1; tick(1);
    @(negedge clk); ca1 = 0; sel = 4'd1; rd_en = 1;
    @(negedge clk); rd_en = 0;
    peek_flags(d); chk("R13 edge beats port read", d, 8'h02);
    wr(4'd13, 8'h7F);
  endtask

  task automatic t_ddr;
    logic [7:0] d;
    wr(4'd3, 8'h0F); wr(4'd1, 8'hFF);
    chk("R9 masked write A", pa_out, 8'h0F);
    wr(4'd3, 8'hF0); wr(4'd15, 8'h00);
    rd(4'd1, d); chk("R9 masked write A again", d, 8'h0F);
    wr(4'd2, 8'h3C); wr(4'd0, 8'hFF);
    chk("R9 masked write B", pb_out, 8'h3C);
    wr(4'd13, 8'h7F);
  endtask

  task automatic t_irq;
    logic [7:0] d;
    wr(4'd12, 8'h00);
    wr(4'd14, 8'h82);
    @(negedge clk); ca1 = 1; tick(1);
    @(negedge clk); ca1 = 0; tick(1);
    chk("R12 irq on", {7'd0, irq}, 8'h01);
    peek_flags(d); chk("R10 summary bit", d, 8'h82);
    wr(4'd14, 8'h02);
    chk("R12 irq masked", {7'd0, irq}, 8'h00);
    peek_flags(d); chk("R10 summary masked", d, 8'h02);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_enable();
    t_line1();
    t_line2();
    t_sr_timers();
    t_portb();
    t_porta();
    t_ddr();
    t_irq();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule